// File: doc/BRIEF.md
# Predicated Execution Nullify Unit

This unit sits between decode and writeback of a simple in-order pipeline and decides, for each instruction slot, whether the instruction's effects are committed. It keeps a file of 64 one-bit predicate flags. Every instruction names one flag as its guard. When the guard is false, the instruction still uses its slot, but its register writeback, its exception and any flag update are suppressed. Compare instructions write a flag. A deferred compare marks a flag as unresolved until a later resolution arrives, and an instruction guarded by an unresolved flag stalls.

Two further operation forms shape the instruction stream. The skip-next form tests an operand against zero and, when it is nonzero, annuls the next valid instruction. The conditional move writes its destination only when its test operand is zero. The annul request is held in a two-state machine. ST_CLEAR moves to ST_ANNUL when an executed skip-next instruction sees a nonzero operand. ST_ANNUL moves back to ST_CLEAR when the next valid instruction takes its slot, and it stays in ST_ANNUL across bubbles.

Top module: `pred_nullify_unit`

## Requirements
- R1: After reset, flag 0 reads 1, every other flag reads 0, no flag is unresolved, and no annul is pending (`out_flags` = 64'h1).
- R2: Flag 0 always reads true, and any compare or resolution aimed at index 0 leaves it unchanged.
- R3: An executed compare (op 1) writes flag `in_dst` with the result of the condition on `in_opnd_a` and `in_opnd_b`: 0 equal, 1 not equal, 2 unsigned less-than, 3 unsigned greater-or-equal. The new value appears on `out_flags` after the edge and guards the instruction in the very next cycle.
- R4: An executed plain instruction (op 0) raises `out_wb_en` equal to `in_wb_req` and `out_exc_en` equal to `in_exc_req` in the same cycle.
- R5: When the selected guard is false, or the slot is annulled, `out_wb_en`, `out_exc_en` and any flag write are suppressed, and `out_stall` stays low: the slot is used and not removed.
- R6: An executed skip-next instruction (op 2) whose `in_opnd_a` is nonzero annuls the next valid instruction. With a zero operand it annuls nothing.
- R7: A pending annul is kept across cycles where `in_valid` is low and is consumed by exactly one valid instruction. An annulled skip-next does not arm a new annul.
- R8: An executed conditional move (op 3) raises `out_wb_en` only when `in_opnd_b` is zero.
- R9: An executed deferred compare (op 4) marks flag `in_dst` unresolved. While the guard of a valid, non-annulled instruction is unresolved, `out_stall` is high with `out_wb_en` and `out_exc_en` low. A resolution (`res_valid`, `res_idx`, `res_value`) writes the flag and clears the mark at the edge, and the held instruction proceeds in the next cycle.
- R10: A compare or deferred compare whose destination flag is unresolved stalls until that flag is resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Slot holds an instruction |
| in_op | input | 3 | Operation: 0 plain, 1 compare, 2 skip-next, 3 conditional move, 4 deferred compare |
| in_guard | input | 6 | Index of the guarding flag |
| in_dst | input | 6 | Destination flag of a compare |
| in_cond | input | 2 | Compare condition code |
| in_opnd_a | input | 32 | First compare operand, skip-next test value |
| in_opnd_b | input | 32 | Second compare operand, conditional-move test value |
| in_wb_req | input | 1 | Plain instruction wants a register writeback |
| in_exc_req | input | 1 | Instruction raised an exception |
| res_valid | input | 1 | Resolution of a deferred compare |
| res_idx | input | 6 | Flag index being resolved |
| res_value | input | 1 | Resolved flag value |
| out_stall | output | 1 | Hold the current instruction |
| out_wb_en | output | 1 | Commit the register writeback |
| out_exc_en | output | 1 | Let the exception be signalled |
| out_flags | output | 64 | Current predicate flags |

## Verification
A flag that holds a wrong value shows up on `out_flags` one edge after the write that should have set it, and it flips `out_wb_en` on the first instruction guarded by that flag. A wrong annul state shows up on the next valid instruction, which commits when it should not or stays silent when it should commit. An unresolved mark that is left standing or cleared too early appears as `out_stall` high for too long or dropping too soon on the instruction that waits for it. Every one of these faults therefore reaches the ports within a single cycle of the instruction that depends on the state.

// File: rtl/pnu_pkg.sv
package pnu_pkg;

    typedef enum logic [2:0] {
        OP_PLAIN = 3'd0,
        OP_CMP   = 3'd1,
        OP_SKIP  = 3'd2,
        OP_CMOV  = 3'd3,
        OP_DCMP  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CND_EQ  = 2'd0,
        CND_NE  = 2'd1,
        CND_LTU = 2'd2,
        CND_GEU = 2'd3
    } cond_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_ANNUL = 1'b1
    } annul_st_e;

endpackage

// File: rtl/pnu_cond_eval.sv
module pnu_cond_eval
    import pnu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        cond,
    output logic              result,
    output logic              a_nonzero,
    output logic              b_zero
);
    cond_e cnd;

    always_comb begin
        cnd = cond_e'(cond);
        unique case (cnd)
            CND_EQ:  result = (opnd_a == opnd_b);
            CND_NE:  result = (opnd_a != opnd_b);
            CND_LTU: result = (opnd_a <  opnd_b);
            CND_GEU: result = (opnd_a >= opnd_b);
        endcase
        a_nonzero = |opnd_a;
        b_zero    = ~|opnd_b;
    end
endmodule

// File: rtl/pnu_flag_file.sv
module pnu_flag_file #(
    parameter int NUM_FLAGS = 64,
    localparam int SEL_W = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_idx,
    input  logic                 wr_val,
    input  logic                 pset_en,
    input  logic [SEL_W-1:0]     pset_idx,
    input  logic                 res_v,
    input  logic [SEL_W-1:0]     res_idx,
    input  logic                 res_val,
    input  logic [SEL_W-1:0]     guard_idx,
    input  logic [SEL_W-1:0]     dst_idx,
    output logic                 guard_val,
    output logic                 guard_pend,
    output logic                 dst_pend,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] pend
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_ent
        if (i == 0) begin : g_hard
            assign flags[i] = 1'b1;
            assign pend[i]  = 1'b0;
        end else begin : g_soft
            logic bit_q;
            logic pnd_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                    pnd_q <= 1'b0;
                end else begin
                    if (res_v && res_idx == SEL_W'(i)) begin
                        bit_q <= res_val;
                        pnd_q <= 1'b0;
                    end
                    if (wr_en && wr_idx == SEL_W'(i)) begin
                        bit_q <= wr_val;
                    end
                    if (pset_en && pset_idx == SEL_W'(i)) begin
                        pnd_q <= 1'b1;
                    end
                end
            end
            assign flags[i] = bit_q;
            assign pend[i]  = pnd_q;
        end
    end

    assign guard_val  = flags[guard_idx];
    assign guard_pend = pend[guard_idx];
    assign dst_pend   = pend[dst_idx];

    AST_CMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && !(res_v && res_idx == wr_idx)) |=> (flags[$past(wr_idx)] == $past(wr_val))); // R3
    AST_RES_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_v && !(pset_en && pset_idx == res_idx)) |=> !pend[$past(res_idx)]); // R9
    AST_ZERO_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> flags[0]); // R2
endmodule

// File: rtl/pnu_annul_fsm.sv
module pnu_annul_fsm
    import pnu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_taken,
    input  logic arm,
    output logic annul
);
    annul_st_e st_q;
    annul_st_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAR: if (slot_taken && arm) st_d = ST_ANNUL;
            ST_ANNUL: if (slot_taken)        st_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        annul = (st_q == ST_ANNUL);
    end

    AST_ANNUL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (annul && slot_taken) |=> !annul); // R7
    AST_BUBBLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (annul && !slot_taken) |=> annul); // R7
endmodule

// File: rtl/pred_nullify_unit.sv
module pred_nullify_unit
    import pnu_pkg::*;
#(
    parameter int NUM_FLAGS = 64,
    parameter int DATA_W    = 32,
    localparam int SEL_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [2:0]           in_op,
    input  logic [SEL_W-1:0]     in_guard,
    input  logic [SEL_W-1:0]     in_dst,
    input  logic [1:0]           in_cond,
    input  logic [DATA_W-1:0]    in_opnd_a,
    input  logic [DATA_W-1:0]    in_opnd_b,
    input  logic                 in_wb_req,
    input  logic                 in_exc_req,
    input  logic                 res_valid,
    input  logic [SEL_W-1:0]     res_idx,
    input  logic                 res_value,
    output logic                 out_stall,
    output logic                 out_wb_en,
    output logic                 out_exc_en,
    output logic [NUM_FLAGS-1:0] out_flags
);
    op_e  op;
    logic cmp_res, a_nz, b_z;
    logic guard_val, guard_pend, dst_pend;
    logic annul, is_cmp_kind, execute, slot_taken;
    logic flag_we, pend_set, arm_skip;
    logic [NUM_FLAGS-1:0] pend_vec;

    assign op = op_e'(in_op);

    pnu_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .opnd_a   (in_opnd_a),
        .opnd_b   (in_opnd_b),
        .cond     (in_cond),
        .result   (cmp_res),
        .a_nonzero(a_nz),
        .b_zero   (b_z)
    );

    pnu_flag_file #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (flag_we),
        .wr_idx    (in_dst),
        .wr_val    (cmp_res),
        .pset_en   (pend_set),
        .pset_idx  (in_dst),
        .res_v     (res_valid),
        .res_idx   (res_idx),
        .res_val   (res_value),
        .guard_idx (in_guard),
        .dst_idx   (in_dst),
        .guard_val (guard_val),
        .guard_pend(guard_pend),
        .dst_pend  (dst_pend),
        .flags     (out_flags),
        .pend      (pend_vec)
    );

    pnu_annul_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_taken(slot_taken),
        .arm       (arm_skip),
        .annul     (annul)
    );

    always_comb begin
        is_cmp_kind = (op == OP_CMP) || (op == OP_DCMP);
        out_stall   = in_valid && !annul &&
                      (guard_pend || (is_cmp_kind && dst_pend));
        slot_taken  = in_valid && !out_stall;
        execute     = slot_taken && !annul && guard_val;
        out_wb_en   = execute && (((op == OP_PLAIN) && in_wb_req) ||
                                  ((op == OP_CMOV) && b_z));
        out_exc_en  = execute && in_exc_req;
        flag_we     = execute && (op == OP_CMP);
        pend_set    = execute && (op == OP_DCMP) && (in_dst != '0);
        arm_skip    = execute && (op == OP_SKIP) && a_nz;
    end

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_stall |-> (!out_wb_en && !out_exc_en)); // R9
    AST_STALL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !annul && pend_vec[in_guard]) |-> out_stall); // R9
    AST_ANNUL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && annul) |-> (!out_stall && !out_wb_en && !out_exc_en)); // R5
    AST_FALSE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_flags[in_guard]) |-> (!out_wb_en && !out_exc_en)); // R5
    AST_CMOV_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMOV && in_opnd_b != '0) |-> !out_wb_en); // R8
    AST_FLAG0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags[0]); // R2
endmodule

// File: tb/pred_nullify_unit_tb_top.sv
module pred_nullify_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [5:0]  in_guard = '0;
    logic [5:0]  in_dst = '0;
    logic [1:0]  in_cond = '0;
    logic [31:0] in_opnd_a = '0;
    logic [31:0] in_opnd_b = '0;
    logic        in_wb_req = 1'b0;
    logic        in_exc_req = 1'b0;
    logic        res_valid = 1'b0;
    logic [5:0]  res_idx = '0;
    logic        res_value = 1'b0;
    logic        out_stall, out_wb_en, out_exc_en;
    logic [63:0] out_flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [63:0] m_flags = 64'h1;
    logic [63:0] m_pend  = 64'h0;
    logic        m_annul = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_nullify_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_guard(in_guard), .in_dst(in_dst), .in_cond(in_cond),
        .in_opnd_a(in_opnd_a), .in_opnd_b(in_opnd_b), .in_wb_req(in_wb_req),
        .in_exc_req(in_exc_req), .res_valid(res_valid), .res_idx(res_idx),
        .res_value(res_value), .out_stall(out_stall), .out_wb_en(out_wb_en),
        .out_exc_en(out_exc_en), .out_flags(out_flags)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic cond_ref(input logic [1:0] c, input logic [31:0] a,
                                      input logic [31:0] b);
        case (c)
            2'd0: return a == b;
            2'd1: return a != b;
            2'd2: return a < b;
            default: return a >= b;
        endcase
    endfunction

    task automatic step(input logic v, input logic [2:0] op, input int g, input int d,
                        input logic [1:0] c, input logic [31:0] a, input logic [31:0] b,
                        input logic wbr, input logic excr,
                        input logic rv, input int ri, input logic rval,
                        input string tag);
        logic stl, ex, wb, exc, cmp_kind;
        @(negedge clk);
        in_valid = v; in_op = op; in_guard = 6'(g); in_dst = 6'(d); in_cond = c;
        in_opnd_a = a; in_opnd_b = b; in_wb_req = wbr; in_exc_req = excr;
        res_valid = rv; res_idx = 6'(ri); res_value = rval;
        cmp_kind = (op == 3'd1) || (op == 3'd4);
        stl = v && !m_annul && (m_pend[g] || (cmp_kind && m_pend[d]));
        ex  = v && !stl && !m_annul && m_flags[g];
        wb  = ex && ((op == 3'd0 && wbr) || (op == 3'd3 && b == 0));
        exc = ex && excr;
        #2;
        chk(tag, "stall", 64'(out_stall), 64'(stl));
        chk(tag, "wb_en", 64'(out_wb_en), 64'(wb));
        chk(tag, "exc_en", 64'(out_exc_en), 64'(exc));
        @(posedge clk);
        if (rv && ri != 0) begin m_flags[ri] = rval; m_pend[ri] = 1'b0; end
        if (ex && op == 3'd1 && d != 0) m_flags[d] = cond_ref(c, a, b);
        if (ex && op == 3'd4 && d != 0) m_pend[d] = 1'b1;
        if (v && !stl) m_annul = m_annul ? 1'b0 : (ex && op == 3'd2 && a != 0);
        #1;
        chk(tag, "flags", out_flags, m_flags);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 3000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<3000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", "reset flags", out_flags, 64'h1);
        chk("R1", "reset stall", 64'(out_stall), 64'h0);
        // R3/R4: every flag written by a compare, then guards the next cycle
        for (int k = 1; k < 64; k++) begin
            step(1, 3'd1, 0, k, 2'(k % 4), 32'(k % 5), 32'(k % 3), 0, 0, 0, 0, 0, "R3");
            step(1, 3'd0, k, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R4");
        end
        // R4/R5: sweep all guards with both request bits
        for (int k = 0; k < 64; k++) begin
            step(1, 3'd0, k, 0, 0, 0, 0, k[0], ~k[0], 0, 0, 0, "R5");
        end
        // R2: writes aimed at flag 0 are ignored
        step(1, 3'd1, 0, 0, 2'd0, 1, 2, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R2");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R2");
        // R5: compare under a false guard leaves its target alone
        step(1, 3'd1, 0, 5, 2'd0, 1, 2, 0, 0, 0, 0, 0, "R5");
        step(1, 3'd1, 0, 6, 2'd1, 3, 3, 0, 0, 0, 0, 0, "R5");
        step(1, 3'd1, 5, 6, 2'd0, 3, 3, 0, 0, 0, 0, 0, "R5");
        // R6/R7: skip-next across bubbles
        step(1, 3'd2, 0, 0, 0, 5, 0, 0, 0, 0, 0, 0, "R6");
        step(0, 3'd0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R7");
        step(0, 3'd0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R7");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R6");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R7");
        step(1, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
        step(1, 3'd2, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 3'd2, 0, 0, 0, 7, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
        step(1, 3'd2, 5, 0, 0, 9, 0, 0, 0, 0, 0, 0, "R6");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
        // R8: conditional move
        step(1, 3'd3, 0, 0, 0, 4, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 3'd3, 0, 0, 0, 4, 9, 0, 0, 0, 0, 0, "R8");
        step(1, 3'd3, 5, 0, 0, 4, 0, 0, 0, 0, 0, 0, "R8");
        // R9: deferred compare, wait and resolve true
        step(1, 3'd4, 0, 20, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 3'd0, 20, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R9");
        step(1, 3'd0, 20, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R9");
        step(1, 3'd0, 20, 0, 0, 0, 0, 1, 1, 1, 20, 1, "R9");
        step(1, 3'd0, 20, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R9");
        // R9: resolve false
        step(1, 3'd4, 0, 21, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 3'd0, 21, 0, 0, 0, 0, 1, 0, 1, 21, 0, "R9");
        step(1, 3'd0, 21, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9");
        // R10: compare into an unresolved flag
        step(1, 3'd4, 0, 22, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(1, 3'd1, 0, 22, 2'd0, 1, 1, 0, 0, 0, 0, 0, "R10");
        step(1, 3'd1, 0, 22, 2'd0, 1, 1, 0, 0, 1, 22, 0, "R10");
        step(1, 3'd1, 0, 22, 2'd0, 1, 1, 0, 0, 0, 0, 0, "R10");
        step(1, 3'd0, 22, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R10");
        // R5: annulled slot with unresolved guard does not stall
        step(1, 3'd4, 0, 23, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 3'd2, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 3'd0, 23, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R5");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1, 1, 1, 23, 1, "R5");
        step(1, 3'd0, 23, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R5");
        finish_run();
    end
endmodule